// File: doc/BRIEF.md
# 64-bit SEC-DED Syndrome Decoder

This block receives a 64-bit data word together with the 8 check bits stored beside it in memory. It recomputes the check byte from the data through a fixed parity-mask matrix and XORs the result with the stored byte to form a syndrome. The syndrome is then classified as clean, a single faulty data bit, a single faulty check bit, or uncorrectable. For the two single-bit cases, the faulty bit is flipped back, and the block returns the repaired data and check byte.

The matrix is not laid out in Hamming position order. A faulty data bit is therefore found by comparing the syndrome against each column of the matrix, starting at data bit 0 and going up, rather than by reading the syndrome as a bit position. One word can enter on every cycle. Its result, marked by `outValid`, appears on the cycle after the word is captured. When no word is captured, the last result stays on the outputs.

Top module: `secded_decoder`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outKind`, `outIndex`, `outSyndrome`, `outData` and `outCheck` are all zero.
- R2: `outValid` is high in exactly the cycles that follow a rising clock edge at which `inValid` was high, so the latency is one cycle.
- R3: Check bit i is the XOR of the data bits selected by the 64-bit mask for row i. In each mask, bits 63:32 are the high-word mask and bits 31:0 are the low-word mask. The masks for rows 0 to 7 are f00fe11e_c33c0ff7, 00ff00ff_00fff0ff, 0f0f0f0f_0f0fff00, 11113333_7777000f, 22224444_8888222f, 44448888_ffff4441, 8888ffff_11118882 and ffff1111_22221114. `outSyndrome` equals the recomputed check byte XOR `inCheck`.
- R4: A zero syndrome gives `outKind` = 0 (clean) and `outIndex` = 0, with data and check bits passed through unchanged.
- R5: The column of data bit n is the 8-bit value whose bit i is bit n of row i's 64-bit mask. If a nonzero syndrome equals one or more columns, the lowest such n is reported with `outKind` = 1 and `outIndex` = n, and `outData` is the input with bit n inverted. `outCheck` is unchanged.
- R6: If a nonzero syndrome matches no column and has exactly one bit set, at position i, the block reports `outKind` = 2 and `outIndex` = i. `outCheck` is the input check byte with bit i inverted, and `outData` is unchanged.
- R7: Any other nonzero syndrome gives `outKind` = 3 (uncorrectable) and `outIndex` = 0, with data and check bits passed through unchanged.
- R8: In a cycle where `inValid` is low, none of the result outputs (`outKind`, `outIndex`, `outSyndrome`, `outData`, `outCheck`) changes.
- R9: Words presented on consecutive cycles each get their own result on consecutive cycles, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture the word on this edge |
| inData | input | 64 | Data word read from memory |
| inCheck | input | 8 | Stored check byte |
| outValid | output | 1 | Result valid |
| outKind | output | 2 | 0 clean, 1 data bit, 2 check bit, 3 uncorrectable |
| outIndex | output | 6 | Faulty data or check bit index |
| outSyndrome | output | 8 | Syndrome of the captured word |
| outData | output | 64 | Corrected data |
| outCheck | output | 8 | Corrected check byte |

## Verification
The bench builds the block with the package defaults, 64 data bits and 8 check bits, which are the only widths the mask matrix defines. At these widths it is possible to inject a single flip at every one of the 64 data positions and all 8 check positions, each on a correctly encoded word. The bench also injects double flips, both data–data and data–check, which exercise the uncorrectable path and the first-match search order. Random words with random check bytes are mixed with idle gaps to exercise the hold behaviour and back-to-back throughput.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    KIND_CLEAN = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_CHECK = 2'd2,
    KIND_FATAL = 2'd3
  } errKind_t;

  typedef struct packed {
    logic load;
  } ctlStrobe_t;

  // Parity-mask row for check bit i; bits 63:32 select high-word data.
  function automatic logic [DATA_W-1:0] rowMask(input int i);
    logic [DATA_W-1:0] m;
    case (i)
      0: m = 64'hf00fe11e_c33c0ff7;
      1: m = 64'h00ff00ff_00fff0ff;
      2: m = 64'h0f0f0f0f_0f0fff00;
      3: m = 64'h11113333_7777000f;
      4: m = 64'h22224444_8888222f;
      5: m = 64'h44448888_ffff4441;
      6: m = 64'h8888ffff_11118882;
      7: m = 64'hffff1111_22221114;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Syndrome expected when data bit n alone is flipped.
  function automatic logic [CHK_W-1:0] column(input int n);
    logic [CHK_W-1:0] c;
    logic [DATA_W-1:0] m;
    for (int i = 0; i < CHK_W; i++) begin
      m = rowMask(i);
      c[i] = m[n];
    end
    return c;
  endfunction
endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctlStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHK_W-1:0]  inCheck,
  output errKind_t          kindQ,
  output logic [IDX_W-1:0]  indexQ,
  output logic [CHK_W-1:0]  syndromeQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [CHK_W-1:0]  checkQ
);
  logic [CHK_W-1:0] recomputed;
  logic [CHK_W-1:0] syndrome;
  logic [CHK_W-1:0] colTable [DATA_W];
  logic [DATA_W-1:0] colHit;

  // Parity trees, one per check row.
  generate
    for (genvar gc = 0; gc < CHK_W; gc++) begin : g_row
      assign recomputed[gc] = ^(inData & rowMask(gc));
    end
  endgenerate

  assign syndrome = recomputed ^ inCheck;

  // Column comparators, one per data position.
  generate
    for (genvar gn = 0; gn < DATA_W; gn++) begin : g_col
      assign colTable[gn] = column(gn);
      assign colHit[gn]   = (syndrome != '0) && (syndrome == colTable[gn]);
    end
  endgenerate

  logic [IDX_W-1:0] dataIdx;
  logic [IDX_W-1:0] chkIdx;
  logic             anyHit;
  logic             singleSet;
  errKind_t         kindD;
  logic [IDX_W-1:0] indexD;
  logic [DATA_W-1:0] dataD;
  logic [CHK_W-1:0]  checkD;

  always_comb begin
    dataIdx = '0;
    for (int n = DATA_W - 1; n >= 0; n--) begin
      if (colHit[n]) dataIdx = IDX_W'(n);
    end
    chkIdx = '0;
    for (int i = CHK_W - 1; i >= 0; i--) begin
      if (syndrome[i]) chkIdx = IDX_W'(i);
    end
    anyHit    = |colHit;
    singleSet = (syndrome != '0) && ((syndrome & (syndrome - 1'b1)) == '0);
  end

  always_comb begin
    kindD  = KIND_CLEAN;
    indexD = '0;
    dataD  = inData;
    checkD = inCheck;
    if (syndrome == '0) begin
      kindD = KIND_CLEAN;
    end else if (anyHit) begin
      kindD          = KIND_DATA;
      indexD         = dataIdx;
      dataD[dataIdx] = ~inData[dataIdx];
    end else if (singleSet) begin
      kindD  = KIND_CHECK;
      indexD = chkIdx;
      checkD = inCheck ^ (CHK_W'(1) << chkIdx);
    end else begin
      kindD = KIND_FATAL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ     <= KIND_CLEAN;
      indexQ    <= '0;
      syndromeQ <= '0;
      dataQ     <= '0;
      checkQ    <= '0;
    end else if (strobe.load) begin
      kindQ     <= kindD;
      indexQ    <= indexD;
      syndromeQ <= syndrome;
      dataQ     <= dataD;
      checkQ    <= checkD;
    end
  end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHK_W-1:0]  inCheck,
  output logic              outValid,
  output logic [1:0]        outKind,
  output logic [IDX_W-1:0]  outIndex,
  output logic [CHK_W-1:0]  outSyndrome,
  output logic [DATA_W-1:0] outData,
  output logic [CHK_W-1:0]  outCheck
);
  ctlStrobe_t strobe;
  errKind_t   kindW;

  secded_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  secded_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .inCheck   (inCheck),
    .kindQ     (kindW),
    .indexQ    (outIndex),
    .syndromeQ (outSyndrome),
    .dataQ     (outData),
    .checkQ    (outCheck)
  );

  assign outKind = kindW;
endmodule

// File: rtl/secded_decoder_chk.sv
module secded_decoder_chk
  import secded_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic [CHK_W-1:0]  inCheck,
  input logic              outValid,
  input logic [1:0]        outKind,
  input logic [IDX_W-1:0]  outIndex,
  input logic [CHK_W-1:0]  outSyndrome,
  input logic [DATA_W-1:0] outData,
  input logic [CHK_W-1:0]  outCheck
);
  always_comb begin
    if (!rstN) begin
      a_reset_r1: assert (outValid == 1'b0 && outKind == 2'd0 && outData == '0);
    end
  end

  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outKind == 2'd0) == (outSyndrome == '0));

  p_data_fix_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outKind == 2'd1) ->
      ($countones(outData ^ $past(inData)) == 1 && outCheck == $past(inCheck)));

  p_check_fix_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outKind == 2'd2) ->
      ($countones(outSyndrome) == 1 && outData == $past(inData) &&
       (outCheck ^ $past(inCheck)) == outSyndrome));

  p_fatal_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outKind == 2'd3) ->
      ($countones(outSyndrome) > 1 && outData == $past(inData) &&
       outCheck == $past(inCheck) && outIndex == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outKind) && $stable(outIndex) && $stable(outSyndrome) &&
                  $stable(outData) && $stable(outCheck)));
endmodule

bind secded_decoder secded_decoder_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inData      (inData),
  .inCheck     (inCheck),
  .outValid    (outValid),
  .outKind     (outKind),
  .outIndex    (outIndex),
  .outSyndrome (outSyndrome),
  .outData     (outData),
  .outCheck    (outCheck)
);

// File: tb/secded_decoder_bench.sv
module secded_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inCheck = '0;
  logic        outValid;
  logic [1:0]  outKind;
  logic [5:0]  outIndex;
  logic [7:0]  outSyndrome;
  logic [63:0] outData;
  logic [7:0]  outCheck;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  secded_decoder u_secded_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCheck(inCheck),
    .outValid(outValid), .outKind(outKind), .outIndex(outIndex),
    .outSyndrome(outSyndrome), .outData(outData), .outCheck(outCheck)
  );

  // Matrix rows from R3.
  function automatic logic [63:0] row(input int i);
    logic [63:0] t [8];
    t[0] = 64'hf00fe11e_c33c0ff7; t[1] = 64'h00ff00ff_00fff0ff;
    t[2] = 64'h0f0f0f0f_0f0fff00; t[3] = 64'h11113333_7777000f;
    t[4] = 64'h22224444_8888222f; t[5] = 64'h44448888_ffff4441;
    t[6] = 64'h8888ffff_11118882; t[7] = 64'hffff1111_22221114;
    return t[i];
  endfunction

  function automatic logic [7:0] encode(input logic [63:0] d);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] m;
      m = row(i);
      c[i] = 1'b0;
      for (int b = 0; b < 64; b++) if (m[b]) c[i] ^= d[b];
    end
    return c;
  endfunction

  // Reference model state.
  logic        eValid;
  logic [1:0]  eKind;
  logic [5:0]  eIndex;
  logic [7:0]  eSyn;
  logic [63:0] eData;
  logic [7:0]  eCheck;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eValid <= 0; eKind <= 0; eIndex <= 0; eSyn <= 0; eData <= 0; eCheck <= 0;
    end else begin
      eValid <= inValid;
      if (inValid) begin
        logic [7:0] s;
        int hit;
        int ones;
        int low;
        s = encode(inData) ^ inCheck;
        hit = -1;
        if (s != 0) begin
          for (int n = 0; n < 64 && hit < 0; n++) begin
            logic [7:0] col;
            for (int i = 0; i < 8; i++) begin
              logic [63:0] m;
              m = row(i);
              col[i] = m[n];
            end
            if (col == s) hit = n;
          end
        end
        ones = 0; low = -1;
        for (int i = 0; i < 8; i++) if (s[i]) begin ones++; if (low < 0) low = i; end
        eSyn <= s;
        if (s == 0) begin
          eKind <= 0; eIndex <= 0; eData <= inData; eCheck <= inCheck;
        end else if (hit >= 0) begin
          eKind <= 1; eIndex <= 6'(hit); eData <= inData ^ (64'd1 << hit); eCheck <= inCheck;
        end else if (ones == 1) begin
          eKind <= 2; eIndex <= 6'(low); eData <= inData; eCheck <= inCheck ^ (8'd1 << low);
        end else begin
          eKind <= 3; eIndex <= 0; eData <= inData; eCheck <= inCheck;
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, 5 ns after the rising edge.
  always @(posedge clk) begin
    #5;
    if (!finished) begin
      string tag;
      if (!rstN) tag = "R1";
      else if (!$past(inValid)) tag = "R8";
      else case (eKind)
        2'd0: tag = "R4";
        2'd1: tag = "R5";
        2'd2: tag = "R6";
        default: tag = "R7";
      endcase
      check(rstN ? "R2 R9 valid" : "R1 valid", 64'(outValid), 64'(eValid));
      check({tag, " kind"}, 64'(outKind), 64'(eKind));
      check({tag, " index"}, 64'(outIndex), 64'(eIndex));
      check({"R3 ", tag, " syndrome"}, 64'(outSyndrome), 64'(eSyn));
      check({tag, " data"}, outData, eData);
      check({tag, " check"}, 64'(outCheck), 64'(eCheck));
    end
  end

  task automatic send(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    inValid = 1'b1; inData = d; inCheck = c;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData = {$urandom, $urandom};
      inCheck = 8'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R1 checked during reset
    rstN = 1'b1;
    idle(2);
    // R4: clean words
    send(64'h0, encode(64'h0));
    send(64'hffffffff_ffffffff, encode(64'hffffffff_ffffffff));
    send(64'h01234567_89abcdef, encode(64'h01234567_89abcdef));
    idle(3);
    // R5, R9: every data bit flipped, back-to-back
    for (int n = 0; n < 64; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      send(d ^ (64'd1 << n), encode(d));
    end
    idle(2);
    // R6: every check bit flipped
    for (int i = 0; i < 8; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      send(d, encode(d) ^ (8'd1 << i));
    end
    idle(1);
    // R7: double flips
    for (int n = 0; n < 63; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      send(d ^ (64'd3 << n), encode(d));
    end
    for (int i = 0; i < 8; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      send(d ^ (64'd1 << (i * 7)), encode(d) ^ (8'd1 << i));
    end
    // Random mix with gaps (R8)
    for (int k = 0; k < 200; k++) begin
      send({$urandom, $urandom}, 8'($urandom));
      if (k % 5 == 0) idle(2);
    end
    idle(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule